// File: doc/BRIEF.md
# Cycle-Stealing Single-Channel DMA Engine

This block moves a block of words between one peripheral port and system memory on behalf of a processor. Software loads a peripheral select, a starting memory address, a word count and a direction through a small register port, then sets a start bit. From then on the engine works alone: for every word it raises a bus request, waits for the arbiter's grant, performs one single-cycle transfer and gives the bus back at once. The processor therefore only loses the bus for single cycles between its own accesses, and no processor context is saved or switched.

When the final word has moved, the engine raises a level interrupt that stays high until software clears it. A start with a zero count completes at once without touching the bus. An abort bit stops a running job; every other register write is refused while a job is in progress. The memory address and remaining count can be read back at any time to follow progress.

Top module: `steal_dma`

## Requirements
- R1: The register port holds five registers, selected by `cfg_addr`: 0 peripheral select, 1 memory address, 2 word count, 3 control (bit 0 direction, 0 = peripheral to memory, 1 = memory to peripheral; bit 1 start; bit 2 abort), 4 status (read: bit 0 busy, bit 1 interrupt pending; write bit 1 = 1 clears the interrupt). Written values read back on `cfg_rdata` in the same cycle the address is applied; a control write without the start bit does not start a job.
- R2: After a start with count N > 0 the engine moves exactly N words with no further register activity: with direction 0 it reads the peripheral and writes memory, with direction 1 it reads memory and writes the peripheral, presenting the programmed peripheral select on `dev_addr` during every transfer.
- R3: `bus_req` rises in the first cycle after the start write and stays high until `bus_gnt` is sampled high; the transfer cycle follows the cycle in which the grant is sampled.
- R4: Each request carries exactly one word: `bus_req` drops in the cycle after the transfer cycle, so the number of request pulses equals the word count.
- R5: The memory address register increments by one and the count register decrements by one with each transferred word; after a job the address reads start + N and the count reads 0.
- R6: `irq` rises two cycles after the last transfer cycle; a start with count 0 sets `irq` in the next cycle with no bus request.
- R7: `irq` stays high until a status write with bit 1 set, and falls in the cycle after that write.
- R8: While busy, writes to every register and a second start are ignored; the job proceeds with its original settings.
- R9: An abort write while busy returns the engine to idle in the next cycle with `bus_req` low and no interrupt; the count register then shows the words not yet moved.
- R10: During and after reset, `bus_req`, `irq` and busy are low and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data (combinational) |
| irq | output | 1 | Completion interrupt, level |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| dev_addr | output | DVW | Peripheral select |
| dev_re | output | 1 | Peripheral read strobe |
| dev_we | output | 1 | Peripheral write strobe |
| dev_rdata | input | DW | Data from the peripheral |
| dev_wdata | output | DW | Data to the peripheral |
| mem_addr | output | AW | Memory address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | DW | Data from memory (combinational read) |
| mem_wdata | output | DW | Data to memory |

## Verification
The transfer path is driven with jobs that vary direction, length (one to six words) and the arbiter's grant delay (zero to five cycles), so a wrong request-hold length, a lost or doubled word, or a swapped data direction shows up as a distinct mismatch in request pulse count, request length or memory contents. A zero-length start separates the immediate-completion path from the normal end of a job. Writes and a second start issued mid-job tell a properly gated register file from one that lets software corrupt a running transfer, and an abort after two words tells a clean stop from one that still raises the interrupt or loses track of the remaining count.

// File: rtl/steal_dma_pkg.sv
package steal_dma_pkg;

  localparam int unsigned CFG_AW = 3;

  localparam logic [CFG_AW-1:0] REG_DEV = 3'd0;
  localparam logic [CFG_AW-1:0] REG_MEM = 3'd1;
  localparam logic [CFG_AW-1:0] REG_CNT = 3'd2;
  localparam logic [CFG_AW-1:0] REG_CTL = 3'd3;
  localparam logic [CFG_AW-1:0] REG_STA = 3'd4;

  localparam int unsigned CTL_DIR   = 0;
  localparam int unsigned CTL_GO    = 1;
  localparam int unsigned CTL_ABORT = 2;
  localparam int unsigned STA_BUSY  = 0;
  localparam int unsigned STA_IRQ   = 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2,
    ST_REL  = 2'd3
  } dma_state_e;

endpackage

// File: rtl/steal_dma_regs.sv
module steal_dma_regs
  import steal_dma_pkg::*;
#(
  parameter int unsigned DW  = 16,
  parameter int unsigned AW  = 16,
  parameter int unsigned CW  = 12,
  parameter int unsigned DVW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic              busy,
  input  logic              step,
  input  logic              done,
  output logic [DVW-1:0]    dev_sel,
  output logic [AW-1:0]     mem_ptr,
  output logic              dir,
  output logic              irq,
  output logic              go,
  output logic              abort,
  output logic              cnt_zero
);

  localparam logic [CW-1:0] CNT_ONE = CW'(1);
  localparam logic [AW-1:0] ADR_ONE = AW'(1);

  logic [DVW-1:0] dev_q, dev_d;
  logic [AW-1:0]  mem_q, mem_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           dir_q, dir_d;
  logic           irq_q, irq_d;
  logic           wr_ok, irq_clr;

  assign wr_ok   = cfg_we && !busy;
  assign irq_clr = wr_ok && (cfg_addr == REG_STA) && cfg_wdata[STA_IRQ];
  assign abort   = cfg_we && (cfg_addr == REG_CTL) && cfg_wdata[CTL_ABORT];
  assign go      = wr_ok && (cfg_addr == REG_CTL) && cfg_wdata[CTL_GO] && !cfg_wdata[CTL_ABORT];

  always_comb begin
    dev_d = dev_q;
    mem_d = mem_q;
    cnt_d = cnt_q;
    dir_d = dir_q;
    irq_d = irq_q;
    if (wr_ok) begin
      case (cfg_addr)
        REG_DEV: dev_d = cfg_wdata[DVW-1:0];
        REG_MEM: mem_d = cfg_wdata[AW-1:0];
        REG_CNT: cnt_d = cfg_wdata[CW-1:0];
        REG_CTL: dir_d = cfg_wdata[CTL_DIR];
        default: ;
      endcase
    end
    if (step) begin
      mem_d = mem_q + ADR_ONE;
      cnt_d = cnt_q - CNT_ONE;
    end
    if (done)         irq_d = 1'b1;
    else if (irq_clr) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q <= '0;
      mem_q <= '0;
      cnt_q <= '0;
      dir_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      dev_q <= dev_d;
      mem_q <= mem_d;
      cnt_q <= cnt_d;
      dir_q <= dir_d;
      irq_q <= irq_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      REG_DEV: cfg_rdata = DW'(dev_q);
      REG_MEM: cfg_rdata = DW'(mem_q);
      REG_CNT: cfg_rdata = DW'(cnt_q);
      REG_CTL: cfg_rdata = DW'(dir_q);
      REG_STA: cfg_rdata = DW'({irq_q, busy});
      default: cfg_rdata = '0;
    endcase
  end

  assign dev_sel  = dev_q;
  assign mem_ptr  = mem_q;
  assign dir      = dir_q;
  assign irq      = irq_q;
  assign cnt_zero = (cnt_q == '0);

  // R5: each word moves the pointer up and the count down by one
  p_step_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt_q == $past(cnt_q) - CNT_ONE) && (mem_q == $past(mem_q) + ADR_ONE));

  // R7: a pending interrupt only falls through a clearing write
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !irq_clr |=> irq_q);

  // R8: while busy, software cannot alter the job settings
  p_busy_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !step |=> $stable(dev_q) && $stable(mem_q) && $stable(cnt_q) && $stable(dir_q));

endmodule

// File: rtl/steal_dma_fsm.sv
module steal_dma_fsm
  import steal_dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic abort,
  input  logic cnt_zero,
  input  logic bus_gnt,
  output logic busy,
  output logic bus_req,
  output logic xfer,
  output logic step,
  output logic done
);

  dma_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    done    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (go) begin
          if (cnt_zero) done    = 1'b1;
          else          state_d = ST_REQ;
        end
      end
      ST_REQ: begin
        if (abort)        state_d = ST_IDLE;
        else if (bus_gnt) state_d = ST_XFER;
      end
      ST_XFER: begin
        if (abort) state_d = ST_IDLE;
        else       state_d = ST_REL;
      end
      ST_REL: begin
        if (abort) begin
          state_d = ST_IDLE;
        end else if (cnt_zero) begin
          state_d = ST_IDLE;
          done    = 1'b1;
        end else begin
          state_d = ST_REQ;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy    = (state_q != ST_IDLE);
  assign bus_req = (state_q == ST_REQ) || (state_q == ST_XFER);
  assign xfer    = (state_q == ST_XFER);
  assign step    = xfer;

  // R3: request is held until the grant arrives
  p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt && !abort |=> bus_req);

  // R3: a transfer cycle is always preceded by a sampled grant
  p_xfer_granted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> $past(bus_gnt));

  // R4: one word per bus tenure, then the bus is released
  p_one_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> !bus_req && !xfer);

  // R6: a zero-length start never touches the bus
  p_zero_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go && cnt_zero |=> !bus_req && !busy);

  // R9: abort stops a running job at once
  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort && busy |=> !busy && !bus_req);

endmodule

// File: rtl/steal_dma.sv
module steal_dma
  import steal_dma_pkg::*;
#(
  parameter int unsigned DW  = 16,
  parameter int unsigned AW  = 16,
  parameter int unsigned CW  = 12,
  parameter int unsigned DVW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  output logic              irq,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [DVW-1:0]    dev_addr,
  output logic              dev_re,
  output logic              dev_we,
  input  logic [DW-1:0]     dev_rdata,
  output logic [DW-1:0]     dev_wdata,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  input  logic [DW-1:0]     mem_rdata,
  output logic [DW-1:0]     mem_wdata
);

  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  logic       busy, step, done, go, abort, cnt_zero, xfer, dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  steal_dma_regs #(
    .DW (DW),
    .AW (AW),
    .CW (CW),
    .DVW(DVW)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .busy     (busy),
    .step     (step),
    .done     (done),
    .dev_sel  (dev_addr),
    .mem_ptr  (mem_addr),
    .dir      (dir),
    .irq      (irq),
    .go       (go),
    .abort    (abort),
    .cnt_zero (cnt_zero)
  );

  steal_dma_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .go      (go),
    .abort   (abort),
    .cnt_zero(cnt_zero),
    .bus_gnt (bus_gnt),
    .busy    (busy),
    .bus_req (bus_req),
    .xfer    (xfer),
    .step    (step),
    .done    (done)
  );

  // single-cycle move; direction picks the source side
  assign dev_re    = xfer && !dir;
  assign mem_we    = xfer && !dir;
  assign mem_re    = xfer && dir;
  assign dev_we    = xfer && dir;
  assign mem_wdata = dev_rdata;
  assign dev_wdata = mem_rdata;

  // R2: strobes of the two directions never overlap
  p_dir_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({mem_we, mem_re}) && (mem_we == dev_re) && (mem_re == dev_we));

endmodule

// File: tb/steal_dma_tb.sv
module steal_dma_tb;

  localparam int DW = 16, AW = 16, CW = 12, DVW = 8;
  localparam logic [2:0] A_DEV = 3'd0, A_MEM = 3'd1, A_CNT = 3'd2, A_CTL = 3'd3, A_STA = 3'd4;

  typedef struct packed {
    logic [7:0]  dev;
    logic [15:0] mem;
    logic [11:0] cnt;
    logic        dir;
    logic [3:0]  dly;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VECS [NV] = '{
    '{dev: 8'h03, mem: 16'd16,  cnt: 12'd4, dir: 1'b0, dly: 4'd0},
    '{dev: 8'h05, mem: 16'd40,  cnt: 12'd3, dir: 1'b1, dly: 4'd2},
    '{dev: 8'h01, mem: 16'd100, cnt: 12'd1, dir: 1'b0, dly: 4'd5},
    '{dev: 8'h07, mem: 16'd60,  cnt: 12'd6, dir: 1'b1, dly: 4'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [DW-1:0] cfg_rdata;
  logic irq, bus_req, bus_gnt;
  logic [DVW-1:0] dev_addr;
  logic dev_re, dev_we, mem_re, mem_we;
  logic [DW-1:0] dev_rdata, dev_wdata, mem_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;

  logic [DW-1:0] mem [256];
  logic [DW-1:0] devlog [64];
  int dev_ctr = 0, dlog_n = 0, xfers = 0, req_rises = 0, run_len = 0, run_bad = 0;
  int dev_bad = 0, cyc = 0, last_x = 0, irq_rise = 0, exp_run = 2, gnt_dly = 0;
  logic [DVW-1:0] exp_dev = '0;
  logic req_prev = 1'b0, irq_prev = 1'b0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  assign dev_rdata = DW'(32'hA000 + dev_ctr);
  assign mem_rdata = mem[mem_addr[7:0]];

  steal_dma #(.DW(DW), .AW(AW), .CW(CW), .DVW(DVW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .dev_addr(dev_addr),
    .dev_re(dev_re), .dev_we(dev_we), .dev_rdata(dev_rdata), .dev_wdata(dev_wdata),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .mem_wdata(mem_wdata)
  );

  // arbiter model: grants after gnt_dly waiting cycles, drops with the request
  initial begin
    int wcnt;
    wcnt = 0;
    bus_gnt = 1'b0;
    forever begin
      @(negedge clk);
      if (!bus_req) begin
        bus_gnt = 1'b0;
        wcnt = 0;
      end else if (wcnt >= gnt_dly) begin
        bus_gnt = 1'b1;
      end else begin
        wcnt++;
      end
    end
  end

  // memory, peripheral and bus observers
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = DW'(32'h5000 + i);
    forever begin
      @(negedge clk);
      cyc++;
      if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
      if (dev_re) dev_ctr++;
      if (dev_we) begin
        devlog[dlog_n % 64] = dev_wdata;
        dlog_n++;
      end
      if (mem_we || mem_re) begin
        xfers++;
        last_x = cyc;
        if (dev_addr != exp_dev) dev_bad++;
      end
      if (bus_req && !req_prev) req_rises++;
      if (bus_req) run_len++;
      else if (run_len != 0) begin
        if (run_len != exp_run) run_bad++;
        run_len = 0;
      end
      req_prev = bus_req;
      if (irq && !irq_prev) irq_rise = cyc;
      irq_prev = irq;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = a;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = int'(cfg_rdata);
  endtask

  task automatic wait_irq(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      #1;
      if (irq) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic run_vec(input vec_t v);
    int x0, r0, rb0, db0, dbase, lbase, bad, val;
    bit ok;
    logic [DW-1:0] e;
    exp_dev = v.dev;
    gnt_dly = int'(v.dly);
    exp_run = int'(v.dly) + 2;
    wr(A_DEV, DW'(v.dev));
    wr(A_MEM, v.mem);
    wr(A_CNT, DW'(v.cnt));
    x0 = xfers; r0 = req_rises; rb0 = run_bad; db0 = dev_bad;
    dbase = dev_ctr; lbase = dlog_n;
    wr(A_CTL, v.dir ? 16'h0003 : 16'h0002);
    check(bus_req == 1'b1, "R3 request in cycle after start", int'(bus_req), 1);
    wait_irq(ok);
    check(ok, "R6 interrupt after block", int'(ok), 1);
    check(irq_rise - last_x == 2, "R6 interrupt latency", irq_rise - last_x, 2);
    check(xfers - x0 == int'(v.cnt), "R2 words moved", xfers - x0, int'(v.cnt));
    check(req_rises - r0 == int'(v.cnt), "R4 one word per request", req_rises - r0, int'(v.cnt));
    check(run_bad == rb0, "R3 request held until grant", run_bad - rb0, 0);
    check(dev_bad == db0, "R2 peripheral select", dev_bad - db0, 0);
    bad = 0;
    for (int k = 0; k < int'(v.cnt); k++) begin
      if (!v.dir) begin
        e = DW'(32'hA000 + dbase + k);
        if (mem[(int'(v.mem) + k) % 256] !== e) bad++;
      end else begin
        e = DW'(32'h5000 + int'(v.mem) + k);
        if (devlog[(lbase + k) % 64] !== e) bad++;
      end
    end
    check(bad == 0, "R2 data words", bad, 0);
    rd(A_MEM, val);
    check(val == int'(v.mem) + int'(v.cnt), "R5 final address", val, int'(v.mem) + int'(v.cnt));
    rd(A_CNT, val);
    check(val == 0, "R5 final count", val, 0);
    rd(A_STA, val);
    check(val == 2, "R6 status after block", val, 2);
    repeat (3) @(negedge clk);
    check(irq == 1'b1, "R7 interrupt held", int'(irq), 1);
    wr(A_STA, 16'h0002);
    check(irq == 1'b0, "R7 interrupt cleared", int'(irq), 0);
  endtask

  initial begin
    int val, x0, n;
    bit ok;

    // R10: reset state
    repeat (3) @(negedge clk);
    check(bus_req == 1'b0 && irq == 1'b0, "R10 outputs in reset", int'({bus_req, irq}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(bus_req == 1'b0 && irq == 1'b0, "R10 outputs after reset", int'({bus_req, irq}), 0);
    rd(A_STA, val); check(val == 0, "R10 status", val, 0);
    rd(A_MEM, val); check(val == 0, "R10 address", val, 0);
    rd(A_CNT, val); check(val == 0, "R10 count", val, 0);

    // R1: programming and read-back, no start without the start bit
    wr(A_DEV, 16'h005A);
    wr(A_MEM, 16'h1234);
    wr(A_CNT, 16'h00AB);
    wr(A_CTL, 16'h0001);
    check(bus_req == 1'b0, "R1 no start without start bit", int'(bus_req), 0);
    rd(A_DEV, val); check(val == 16'h5A, "R1 peripheral select", val, 16'h5A);
    rd(A_MEM, val); check(val == 16'h1234, "R1 memory address", val, 16'h1234);
    rd(A_CNT, val); check(val == 16'hAB, "R1 count", val, 16'hAB);
    rd(A_CTL, val); check(val == 1, "R1 direction", val, 1);
    rd(A_STA, val); check(val == 0, "R1 idle status", val, 0);

    // main vector table
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R6: zero count completes at once
    x0 = xfers;
    wr(A_CNT, 16'h0000);
    wr(A_CTL, 16'h0002);
    check(irq == 1'b1, "R6 zero count interrupt", int'(irq), 1);
    check(bus_req == 1'b0, "R6 zero count no request", int'(bus_req), 0);
    repeat (5) @(negedge clk);
    check(xfers == x0 && bus_req == 1'b0, "R6 zero count no transfer", xfers - x0, 0);
    wr(A_STA, 16'h0002);
    check(irq == 1'b0, "R7 clear after zero count", int'(irq), 0);

    // R8: writes while busy are ignored
    exp_dev = 8'h21; gnt_dly = 3; exp_run = 5;
    wr(A_DEV, 16'h0021);
    wr(A_MEM, 16'd120);
    wr(A_CNT, 16'd3);
    x0 = xfers;
    wr(A_CTL, 16'h0002);
    rd(A_STA, val); check(val == 1, "R8 busy while running", val, 1);
    wr(A_MEM, 16'd200);
    wr(A_DEV, 16'h0009);
    wr(A_CNT, 16'd50);
    wr(A_CTL, 16'h0003);
    wait_irq(ok);
    check(ok, "R8 job completes", int'(ok), 1);
    check(xfers - x0 == 3, "R8 word count kept", xfers - x0, 3);
    rd(A_MEM, val); check(val == 123, "R8 address kept", val, 123);
    rd(A_DEV, val); check(val == 16'h21, "R8 select kept", val, 16'h21);
    rd(A_CTL, val); check(val == 0, "R8 direction kept", val, 0);
    check(mem[122] == DW'(32'hA000 + dev_ctr - 1), "R8 data to original area", int'(mem[122]), dev_ctr - 1 + 32'hA000);
    wr(A_STA, 16'h0002);

    // R9: abort mid-job
    exp_dev = 8'h33; gnt_dly = 3; exp_run = 5;
    wr(A_DEV, 16'h0033);
    wr(A_MEM, 16'd150);
    wr(A_CNT, 16'd5);
    x0 = xfers;
    wr(A_CTL, 16'h0002);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      #1;
      if (xfers - x0 >= 2) break;
    end
    wr(A_CTL, 16'h0004);
    check(bus_req == 1'b0, "R9 request dropped", int'(bus_req), 0);
    n = xfers - x0;
    rd(A_STA, val); check(val == 0, "R9 idle, no interrupt", val, 0);
    repeat (10) @(negedge clk);
    check(irq == 1'b0 && xfers - x0 == n, "R9 no further activity", xfers - x0, n);
    rd(A_CNT, val); check(val == 5 - n, "R9 remaining count", val, 5 - n);
    rd(A_MEM, val); check(val == 150 + n, "R9 stopped address", val, 150 + n);

    summary();
    $finish;
  end

endmodule